// File: doc/BRIEF.md
# Critical-Conduction Boost Gate Sequencer

This block drives the gate of the boost switch in a power-factor-correction stage that runs in critical-conduction mode. It receives comparator results that are already digital: the zero-crossing flag from the inductor's auxiliary winding, an over-current trip, bus over-voltage and undervoltage flags, and an enable from a supervising controller. Low enable means fault or disabled. It also receives an on-time count from the error loop and an extension count. The extension lengthens the on-time near the zero-crossings of the rectified line. Every flag passes through a two-flop synchronizer before the block uses it.

Each on-pulse lasts the sum of the base and extension counts, clipped at a maximum. A new pulse starts on a falling edge of the zero-crossing flag, which means the inductor current has reached zero. If no such edge arrives, a watchdog forces a pulse every `WD_CYCLES` clock cycles. When the over-voltage flag releases, the block fires one forced pulse at once.

The sequencer is a four-state machine:
- `ST_OFF`: the block is disabled.
- `ST_WAIT`: the gate is off and the block waits for a restart.
- `ST_ON`: the gate is high.
- `ST_OVP`: over-voltage holds the gate low.

Its transitions are:
- `enable` (OFF→WAIT).
- `restart` (WAIT→ON, on a zero-crossing fall or a watchdog expiry with a non-zero length).
- `finish` (ON→WAIT, when the length is reached).
- `trip` (ON→WAIT, on over-current).
- `clamp` (any enabled state→OVP).
- `release` (OVP→ON, or OVP→WAIT if the length is zero).
- `shutdown` (any state→OFF when the enable is low or undervoltage is set).

Top module: `pfc_gate_seq`

## Requirements
- R1: During and after reset, `gate_out` is low and the sequencer is in `ST_OFF`.
- R2: In `ST_WAIT`, a falling edge on `zx_in` starts a pulse. `gate_out` is high on the third clock after the input falls: two synchronizer stages plus the state register. A rising edge alone starts nothing.
- R3: The pulse width in clocks is `min(on_base + on_ext, ON_MAX)`. The value is captured when the pulse starts.
- R4: When the clipped length is zero, a restart event produces no pulse and `gate_out` stays low.
- R5: The watchdog counter clears on every turn-on and while the block is in `ST_OFF` or `ST_OVP`. If `WD_CYCLES` clocks pass with no zero-crossing fall, a forced pulse starts. Forced pulses therefore start exactly `WD_CYCLES` clocks apart. `ON_MAX` is less than `WD_CYCLES`, so the watchdog never expires while the gate is high.
- R6: If the synchronized `oc_in` is high while the gate is high, the gate goes low on the next clock. The block then waits for a zero-crossing fall or a watchdog expiry.
- R7: While the synchronized `ov_in` is high, `gate_out` is low and restart events are ignored. When it releases, a pulse of the programmed length starts at once: the gate is high on the third clock after `ov_in` falls.
- R8: When `en_in` is low or `uv_in` is high, the gate goes low on the next clock after synchronization and restart events are ignored. After the condition clears, the first pulse needs a zero-crossing fall or a full watchdog period. With `zx_in` idle, the gate rises `WD_CYCLES + 3` clocks after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_in | input | 1 | Supervisor enable; low means fault or disabled |
| uv_in | input | 1 | Bus undervoltage flag |
| ov_in | input | 1 | Bus over-voltage flag |
| oc_in | input | 1 | Switch over-current flag |
| zx_in | input | 1 | Zero-crossing flag from the auxiliary winding |
| on_base | input | CNT_W | On-time count from the error loop |
| on_ext | input | CNT_W | On-time extension count near line zero-crossings |
| gate_out | output | 1 | Boost switch gate command |

## Verification
The pulse width is swept over a grid of base and extension counts. The grid includes the zero-length case and sums above the clip limit, so plain addition, saturation and suppression of empty pulses are each shown apart. Restart is tried three ways:
- a falling zero-crossing edge, checked for exact latency;
- a rising edge with nothing after it;
- no edge at all, checked for the first-expiry delay and the forced-pulse period.

Over-current, over-voltage, undervoltage and enable are each applied around a live pulse. The bench checks that each one cuts or holds the gate, and then how the next pulse is allowed to start.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_ON   = 2'd2,
        ST_OVP  = 2'd3
    } pfc_state_e;

    localparam int NUM_FLAGS = 5;
    localparam int FLG_EN = 0;
    localparam int FLG_UV = 1;
    localparam int FLG_OV = 2;
    localparam int FLG_OC = 3;
    localparam int FLG_ZX = 4;

endpackage

// File: rtl/pfc_flag_sync.sv
module pfc_flag_sync #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_in,
    output logic [N-1:0] q_out
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d_in[i];
                s2 <= s1;
            end
        end
        assign q_out[i] = s2;
    end

endmodule

// File: rtl/pfc_wdog.sv
module pfc_wdog #(
    parameter int WD_CYCLES = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expire
);

    localparam int WD_W = (WD_CYCLES > 1) ? $clog2(WD_CYCLES) : 1;
    localparam logic [WD_W-1:0] WD_LAST = WD_W'(WD_CYCLES - 1);

    logic [WD_W-1:0] cnt;

    assign expire = (cnt == WD_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr || expire)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R5
    wd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= WD_LAST);

endmodule

// File: rtl/pfc_ontime.sv
module pfc_ontime #(
    parameter int CNT_W  = 8,
    parameter int ON_MAX = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] base,
    input  logic [CNT_W-1:0] ext,
    input  logic             start,
    input  logic             active,
    output logic             len_zero,
    output logic             done
);

    localparam logic [CNT_W:0] MAX_W = (CNT_W+1)'(ON_MAX);

    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] len_sat;
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] cnt;

    assign sum      = {1'b0, base} + {1'b0, ext};
    assign len_sat  = (sum > MAX_W) ? MAX_W[CNT_W-1:0] : sum[CNT_W-1:0];
    assign len_zero = (len_sat == '0);
    assign done     = active && (cnt >= len_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
            cnt   <= '0;
        end else if (start) begin
            len_q <= len_sat;
            cnt   <= CNT_W'(1);
        end else if (active) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3
    on_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt <= len_q));

    // R4
    nonzero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (len_q != '0));

endmodule

// File: rtl/pfc_gate_seq.sv
module pfc_gate_seq
    import pfc_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int ON_MAX    = 200,
    parameter int WD_CYCLES = 20000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_in,
    input  logic             uv_in,
    input  logic             ov_in,
    input  logic             oc_in,
    input  logic             zx_in,
    input  logic [CNT_W-1:0] on_base,
    input  logic [CNT_W-1:0] on_ext,
    output logic             gate_out
);

    pfc_state_e state, nxt;
    logic [NUM_FLAGS-1:0] raw, syn;
    logic en_s, uv_s, ov_s, oc_s, zx_s, zx_prev, zx_fall;
    logic enabled, start, wd_clr, wd_exp, len_zero, on_done;

    assign raw[FLG_EN] = en_in;
    assign raw[FLG_UV] = uv_in;
    assign raw[FLG_OV] = ov_in;
    assign raw[FLG_OC] = oc_in;
    assign raw[FLG_ZX] = zx_in;

    pfc_flag_sync #(.N(NUM_FLAGS)) i_sync (
        .clk(clk), .rst_n(rst_n), .d_in(raw), .q_out(syn)
    );

    assign en_s = syn[FLG_EN];
    assign uv_s = syn[FLG_UV];
    assign ov_s = syn[FLG_OV];
    assign oc_s = syn[FLG_OC];
    assign zx_s = syn[FLG_ZX];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) zx_prev <= 1'b0;
        else        zx_prev <= zx_s;
    end

    assign zx_fall = zx_prev && !zx_s;
    assign enabled = en_s && !uv_s;
    assign wd_clr  = start || (state == ST_OFF) || (state == ST_OVP);

    pfc_wdog #(.WD_CYCLES(WD_CYCLES)) i_wdog (
        .clk(clk), .rst_n(rst_n), .clr(wd_clr), .expire(wd_exp)
    );

    pfc_ontime #(.CNT_W(CNT_W), .ON_MAX(ON_MAX)) i_ontime (
        .clk(clk), .rst_n(rst_n), .base(on_base), .ext(on_ext),
        .start(start), .active(state == ST_ON),
        .len_zero(len_zero), .done(on_done)
    );

    // next-state logic
    always_comb begin
        nxt   = state;
        start = 1'b0;
        if (!enabled) begin
            nxt = ST_OFF;
        end else if (ov_s) begin
            nxt = ST_OVP;
        end else begin
            unique case (state)
                ST_OFF:  nxt = ST_WAIT;
                ST_WAIT: if ((zx_fall || wd_exp) && !len_zero) begin
                             nxt   = ST_ON;
                             start = 1'b1;
                         end
                ST_ON:   if (oc_s || on_done) nxt = ST_WAIT;
                ST_OVP:  if (!len_zero) begin
                             nxt   = ST_ON;
                             start = 1'b1;
                         end else begin
                             nxt = ST_WAIT;
                         end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // output process
    always_comb begin
        gate_out = (state == ST_ON);
    end

    // R8
    disable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |=> !gate_out);

    // R7
    ov_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ov_s |=> !gate_out);

    // R6
    oc_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_out && oc_s) |=> !gate_out);

    // R5
    wd_not_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_out |-> !wd_exp);

    // R2
    rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_out) |-> $past(zx_fall || wd_exp || state == ST_OVP));

endmodule

// File: tb/test_pfc_gate_seq.sv
module test_pfc_gate_seq;

    localparam int CNT_W = 5;
    localparam int ON_MAX = 20;
    localparam int WD = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_in = 1'b0, uv_in = 1'b0, ov_in = 1'b0, oc_in = 1'b0, zx_in = 1'b0;
    logic [CNT_W-1:0] on_base = '0, on_ext = '0;
    logic gate_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pfc_gate_seq #(.CNT_W(CNT_W), .ON_MAX(ON_MAX), .WD_CYCLES(WD)) i_pfc_gate_seq (
        .clk(clk), .rst_n(rst_n), .en_in(en_in), .uv_in(uv_in), .ov_in(ov_in),
        .oc_in(oc_in), .zx_in(zx_in), .on_base(on_base), .on_ext(on_ext),
        .gate_out(gate_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // count negedges until gate is high (cap 200)
    task automatic time_to_rise(output int n);
        n = 0;
        while (n < 200) begin
            @(negedge clk);
            n++;
            if (gate_out) break;
        end
    endtask

    task automatic width(output int w);
        w = 1;
        while (w < 100) begin
            @(negedge clk);
            if (!gate_out) break;
            w++;
        end
    endtask

    function automatic int clip(input int b, input int e);
        return (b + e > ON_MAX) ? ON_MAX : b + e;
    endfunction

    // zero-crossing falling edge, then measure the resulting pulse
    task automatic zx_pulse(input string req, input int exp);
        int w;
        zx_in = 1'b0;
        tick(2);
        chk({req, " latency low"}, gate_out, 0);
        tick(1);
        if (exp == 0) begin
            chk({req, " zero length"}, gate_out, 0);
            tick(4);
            chk({req, " zero length later"}, gate_out, 0);
        end else begin
            chk({req, " latency high"}, gate_out, 1);
            width(w);
            chk({req, " width"}, w, exp);
        end
        zx_in = 1'b1;
        tick(2);
    endtask

    initial begin
        int n, w;
        tick(3);
        // R1: reset state
        chk("R1 reset gate", gate_out, 0);
        rst_n = 1'b1;
        tick(3);
        chk("R1 after reset", gate_out, 0);

        // R5 / R8: enable with idle zx -> first forced pulse after WD+3
        on_base = 5'd4;
        en_in = 1'b1;
        time_to_rise(n);
        chk("R8 first pulse delay", n, WD + 3);
        width(w);
        chk("R5 forced width", w, 4);
        n = w;
        while (n < 200) begin
            @(negedge clk);
            n++;
            if (gate_out) break;
        end
        chk("R5 forced period", n, WD);
        width(w);

        // R2: rising edge alone does nothing
        zx_in = 1'b1;
        tick(6);
        chk("R2 rising edge only", gate_out, 0);

        // R3 / R4: sweep base x ext
        for (int b = 0; b < 8; b++) begin
            for (int e = 0; e < 4; e++) begin
                on_base = CNT_W'(b);
                on_ext  = CNT_W'(e);
                zx_pulse((b + e == 0) ? "R4" : "R3", clip(b, e));
            end
        end
        // R3 saturation
        on_base = 5'd15; on_ext = 5'd10;
        zx_pulse("R3 saturate", ON_MAX);
        on_base = 5'd20; on_ext = 5'd0;
        zx_pulse("R3 at max", ON_MAX);
        on_base = 5'd31; on_ext = 5'd31;
        zx_pulse("R3 both max", ON_MAX);

        // R6: over-current cuts the pulse
        on_base = 5'd15; on_ext = 5'd0;
        zx_in = 1'b0;
        tick(3);
        chk("R6 pulse up", gate_out, 1);
        oc_in = 1'b1;
        tick(2);
        chk("R6 before cut", gate_out, 1);
        tick(1);
        chk("R6 cut", gate_out, 0);
        oc_in = 1'b0;
        tick(10);
        chk("R6 stays off", gate_out, 0);
        zx_in = 1'b1;
        tick(2);
        on_base = 5'd6;
        zx_pulse("R6 restart", 6);

        // R7: over-voltage holds gate low, release forces pulse
        ov_in = 1'b1;
        tick(3);
        zx_in = 1'b0;
        tick(4);
        chk("R7 zx ignored", gate_out, 0);
        zx_in = 1'b1;
        n = 0;
        for (int i = 0; i < 2 * WD; i++) begin
            @(negedge clk);
            if (gate_out) n++;
        end
        chk("R7 held low", n, 0);
        on_base = 5'd7;
        ov_in = 1'b0;
        tick(2);
        chk("R7 release low", gate_out, 0);
        tick(1);
        chk("R7 release pulse", gate_out, 1);
        width(w);
        chk("R7 release width", w, 7);

        // R8: undervoltage during a pulse
        on_base = 5'd12;
        zx_in = 1'b0;
        tick(4);
        chk("R8 pulse up", gate_out, 1);
        uv_in = 1'b1;
        tick(3);
        chk("R8 uv cut", gate_out, 0);
        zx_in = 1'b1;
        tick(3);
        zx_in = 1'b0;
        tick(5);
        chk("R8 uv zx ignored", gate_out, 0);
        uv_in = 1'b0;
        time_to_rise(n);
        chk("R8 uv release delay", n, WD + 3);
        width(w);

        // R8: enable low
        en_in = 1'b0;
        zx_in = 1'b1;
        tick(3);
        zx_in = 1'b0;
        tick(5);
        chk("R8 disabled zx ignored", gate_out, 0);
        en_in = 1'b1;
        time_to_rise(n);
        chk("R8 re-enable delay", n, WD + 3);
        width(w);
        chk("R8 re-enable width", w, 12);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hang expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule